// File: doc/BRIEF.md
# Auxiliary Event Timestamp Snapshot FIFO

This block records the moment of an external event. A trigger pin, asynchronous to the time-base clock, is brought into that clock domain and edge-detected. Each accepted rising edge stores the current seconds and nanoseconds of the system time into a small queue. The system time counter is outside the block and arrives as two input buses.

Software drains the queue one word at a time. It first fetches the nanoseconds word of the oldest entry, then the seconds word. Fetching the seconds word retires that entry. Status outputs give the number of stored snapshots, a pending flag suitable for an interrupt line and a sticky overflow flag. A clear strobe empties the queue and drops the overflow flag.

Edges that follow an accepted event too closely are dropped deliberately, so that the capture rate is bounded.

Top module: `aux_snap_fifo`

## Requirements
- R1: While reset is asserted and right after it, the snapshot count is 0, the pending and overflow flags are 0 and the read data is 0.
- R2: A rising edge of the trigger that is set up before clock edge P1 is sampled through two synchronizer stages. On edge P3 it stores the seconds and nanoseconds present at the inputs. The count is unchanged after P2 and has risen by one after P3.
- R3: A trigger held high for many cycles yields exactly one snapshot.
- R4: A synchronized edge that arrives fewer than MIN_GAP (4) clock cycles after the previous accepted edge is dropped. An edge that arrives MIN_GAP or more cycles later is accepted.
- R5: A read strobe with select 0 (nanoseconds word) returns the head entry's nanoseconds on the read data one cycle later and leaves the count unchanged.
- R6: A read strobe with select 1 (seconds word) returns the head entry's seconds one cycle later, removes that entry and lowers the count by one.
- R7: Entries are returned oldest first.
- R8: A read of either word while the queue is empty returns 0 and leaves the count at 0.
- R9: A trigger accepted while DEPTH (4) entries are held, with no removal in the same cycle, is discarded. It leaves the stored entries intact and sets the overflow flag, which stays set until a clear.
- R10: A clear strobe sets the count to 0 and the overflow flag to 0 on the next cycle.
- R11: The pending flag is 1 exactly when the count is nonzero.
- R12: The count never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Asynchronous event trigger |
| sys_sec_i | input | 32 | Current system time, seconds |
| sys_nsec_i | input | 32 | Current system time, nanoseconds |
| clr_i | input | 1 | Empty the queue and clear overflow |
| rd_en_i | input | 1 | Read strobe |
| rd_sel_i | input | 1 | Word select: 0 nanoseconds, 1 seconds (retires entry) |
| rd_data_o | output | 32 | Registered read data |
| snap_cnt_o | output | 3 | Number of stored snapshots |
| snap_pend_o | output | 1 | At least one snapshot stored |
| snap_ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its defaults: DEPTH 4, MIN_GAP 4 and two synchronizer stages. With a queue this shallow, every fill level from empty to full, the overflow boundary and a full drain in order all fit in a few hundred cycles. The small gap makes it possible to sweep edge spacings from 2 to 7 cycles, which covers both sides of the drop threshold. The bench also counts the cycles from the trigger to the capture.

// File: rtl/aux_snap_pkg.sv
package aux_snap_pkg;

  localparam int TS_SEC_W  = 32;
  localparam int TS_NSEC_W = 32;
  localparam int TS_DATA_W = (TS_SEC_W > TS_NSEC_W) ? TS_SEC_W : TS_NSEC_W;

  typedef struct packed {
    logic [TS_SEC_W-1:0]  sec;
    logic [TS_NSEC_W-1:0] nsec;
  } stamp_t;

  typedef enum logic {
    WORD_NSEC = 1'b0,
    WORD_SEC  = 1'b1
  } rd_word_e;

endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  // shift chain, first stage takes the raw pin
  always_comb begin
    sync_d[0] = trig_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_comb begin
      sync_d[s] = sync_q[s-1];
    end
  end

  always_comb begin
    prev_d = sync_q[STAGES-1];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_flop
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= 1'b0;
      else        sync_q[s] <= sync_d[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign edge_o = sync_q[STAGES-1] & ~prev_q;

  // R3
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);

endmodule

// File: rtl/gap_filter.sv
module gap_filter #(
  parameter int MIN_GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic evt_o
);

  localparam int HOLD_W = (MIN_GAP > 1) ? $clog2(MIN_GAP) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(MIN_GAP - 1);

  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] hold_d;
  logic              idle;

  assign idle  = (hold_q == '0);
  assign evt_o = edge_i & idle;

  always_comb begin
    hold_d = hold_q;
    if (evt_o)      hold_d = HOLD_LOAD;
    else if (!idle) hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  // R4
  hold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= HOLD_LOAD);

  if (MIN_GAP > 1) begin : g_gap_chk
    // R4
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> !evt_o);
  end

endmodule

// File: rtl/snap_store.sv
module snap_store
  import aux_snap_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push_i,
  input  stamp_t               stamp_i,
  input  logic                 clr_i,
  input  logic                 rd_en_i,
  input  logic                 rd_sel_i,
  output logic [TS_DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]     count_o,
  output logic                 ovf_o
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  stamp_t                mem_q [DEPTH];
  logic [PTR_W-1:0]      wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]      rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  ovf_q, ovf_d;
  logic [TS_DATA_W-1:0]  rdat_q, rdat_d;
  logic                  empty, full;
  logic                  pop, do_push, drop;
  stamp_t                head;
  rd_word_e              word_sel;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == FULL_CNT);
  assign word_sel = rd_word_e'(rd_sel_i);
  assign pop      = rd_en_i && (word_sel == WORD_SEC) && !empty && !clr_i;
  assign do_push  = push_i && (!full || pop) && !clr_i;
  assign drop     = push_i && full && !pop && !clr_i;
  assign head     = mem_q[rd_ptr_q];

  // pointer and occupancy next state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    ovf_d    = ovf_q;
    if (clr_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
      ovf_d    = 1'b0;
    end else begin
      if (do_push) wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (pop)     rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
      if (drop) ovf_d = 1'b1;
    end
  end

  // read data next state
  always_comb begin
    rdat_d = rdat_q;
    if (rd_en_i) begin
      if (empty)                        rdat_d = '0;
      else if (word_sel == WORD_SEC)    rdat_d = TS_DATA_W'(head.sec);
      else                              rdat_d = TS_DATA_W'(head.nsec);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
      rdat_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      ovf_q    <= ovf_d;
      rdat_q   <= rdat_d;
    end
  end

  // storage: one enabled register per slot
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic slot_we;
    assign slot_we = do_push && (wr_ptr_q == PTR_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[e] <= '0;
      else if (slot_we) mem_q[e] <= stamp_i;
    end
  end

  assign rd_data_o = rdat_q;
  assign count_o   = cnt_q;
  assign ovf_o     = ovf_q;

  // R12
  count_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0) && !ovf_q);

  // R6
  pop_lowers_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !do_push) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R9
  overflow_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q && (cnt_q == FULL_CNT));

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_i) |=> ovf_q);

  // R8
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && empty) |=> (rdat_q == '0) && (cnt_q == '0));

endmodule

// File: rtl/aux_snap_fifo.sv
module aux_snap_fifo
  import aux_snap_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int MIN_GAP     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trig_i,
  input  logic [TS_SEC_W-1:0]  sys_sec_i,
  input  logic [TS_NSEC_W-1:0] sys_nsec_i,
  input  logic                 clr_i,
  input  logic                 rd_en_i,
  input  logic                 rd_sel_i,
  output logic [TS_DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]     snap_cnt_o,
  output logic                 snap_pend_o,
  output logic                 snap_ovf_o
);

  logic   trig_edge;
  logic   trig_evt;
  stamp_t now_stamp;

  assign now_stamp.sec  = sys_sec_i;
  assign now_stamp.nsec = sys_nsec_i;

  trig_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .edge_o (trig_edge)
  );

  gap_filter #(.MIN_GAP(MIN_GAP)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .edge_i (trig_edge),
    .evt_o  (trig_evt)
  );

  snap_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (trig_evt),
    .stamp_i   (now_stamp),
    .clr_i     (clr_i),
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o),
    .count_o   (snap_cnt_o),
    .ovf_o     (snap_ovf_o)
  );

  assign snap_pend_o = (snap_cnt_o != '0);

  // R2
  capture_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt && !clr_i && (snap_cnt_o == '0)) |=> (snap_cnt_o == CNT_W'(1)));

  // R11
  pending_follows_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snap_pend_o) |-> ($past(snap_cnt_o) == '0));

endmodule

// File: tb/aux_snap_fifo_bench.sv
module aux_snap_fifo_bench;

  localparam int DEPTH   = 4;
  localparam int MIN_GAP = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig;
  logic [31:0] sec, nsec;
  logic        clr, rd_en, rd_sel;
  logic [31:0] rd_data;
  logic [2:0]  cnt;
  logic        pend, ovf;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  aux_snap_fifo u_aux_snap_fifo (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .sys_sec_i(sec), .sys_nsec_i(nsec),
    .clr_i(clr), .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .snap_cnt_o(cnt), .snap_pend_o(pend), .snap_ovf_o(ovf)
  );

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic fire(input logic [31:0] s, input logic [31:0] ns);
    sec = s; nsec = ns; trig = 1'b1;
    repeat (3) tick();
    trig = 1'b0;
    repeat (MIN_GAP + 4) tick();
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    rd_en = 1'b1; rd_sel = sel;
    tick();
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic clear();
    clr = 1'b1; tick(); clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; trig = 0; sec = 0; nsec = 0; clr = 0; rd_en = 0; rd_sel = 0;
    repeat (3) tick();
    chk("R1 count", cnt, 0); chk("R1 pend", pend, 0);
    chk("R1 ovf", ovf, 0);   chk("R1 data", rd_data, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 count after release", cnt, 0);

    // R2 latency: trigger set before P1, capture on P3
    sec = 32'h0000_0011; nsec = 32'h0000_0022; trig = 1'b1;
    tick(); tick();
    chk("R2 count before P3", cnt, 0);
    tick();
    chk("R2 count after P3", cnt, 1);
    chk("R11 pend set", pend, 1);
    // R3 held-high trigger
    repeat (20) tick();
    trig = 1'b0;
    repeat (6) tick();
    chk("R3 single capture", cnt, 1);

    rd(1'b0, d);
    chk("R5 nsec word", d, 32'h22); chk("R5 count kept", cnt, 1);
    rd(1'b1, d);
    chk("R6 sec word", d, 32'h11);  chk("R6 count drop", cnt, 0);
    chk("R11 pend clear", pend, 0);

    // R4 edge-spacing sweep
    for (int k = 2; k <= 7; k++) begin
      clear();
      trig = 1'b1; tick(); trig = 1'b0;
      repeat (k - 1) tick();
      trig = 1'b1; tick(); trig = 1'b0;
      repeat (10) tick();
      chk($sformatf("R4 spacing %0d", k), cnt, (k >= MIN_GAP) ? 2 : 1);
    end

    // R7 / R9 fill, overflow and ordered drain
    clear();
    for (int i = 0; i < DEPTH; i++) begin
      fire(32'd100 + i, 32'd5000 + 13 * i);
      chk("R12 fill count", cnt, i + 1);
    end
    chk("R9 no ovf when just full", ovf, 0);
    fire(32'hDEAD, 32'hBEEF);
    chk("R9 count stays", cnt, DEPTH); chk("R9 ovf set", ovf, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(1'b0, d);
      chk("R7 nsec order", d, 32'd5000 + 13 * i);
      chk("R5 count after nsec", cnt, DEPTH - i);
      rd(1'b1, d);
      chk("R7 sec order", d, 32'd100 + i);
      chk("R6 count after sec", cnt, DEPTH - i - 1);
    end
    chk("R9 ovf sticky", ovf, 1);

    // R8 empty reads
    rd(1'b0, d); chk("R8 empty nsec", d, 0); chk("R8 count", cnt, 0);
    rd(1'b1, d); chk("R8 empty sec", d, 0);  chk("R8 count", cnt, 0);

    // R10 clear
    fire(32'd7, 32'd8); fire(32'd9, 32'd10);
    chk("R10 before clear", cnt, 2);
    clear();
    chk("R10 count", cnt, 0); chk("R10 ovf", ovf, 0); chk("R11 pend", pend, 0);
    rd(1'b1, d); chk("R10 empty after clear", d, 0);

    summary();
    $finish;
  end

endmodule